// File: doc/BRIEF.md
# Serial Flash Read Responder (Single-Bit Fast Read and Quad I/O Read)

This block is the read side of a serial flash device model. It watches chip select and the serial clock and collects command, address and mode bits on each falling SCK edge. It then streams bytes from a memory array back to the host. Two read commands are served. The first is a single-bit fast read: opcode 0x0B, a 24-bit address on one line, then one dummy byte. The second is a quad I/O read: opcode 0xEB, then address, mode byte and dummy clocks on four lines.

After a quad I/O read, the mode byte decides the next transaction. If its upper nibble is 0xA, the responder stays in quad mode across the chip-select gap, and the next transaction starts straight with the address nibbles, with no opcode. Any other mode value returns the responder to opcode decoding. While the array reports a write in progress, every byte loaded for output is zero.

The whole block runs on one system clock. SCK, chip select and the input lines are sampled as ordinary synchronous inputs. The array is read through a combinational port that returns the byte at the presented address in the same cycle.

Top module: `qrd_read_responder`

## Requirements
- R1: After reset, `dout` is 0, `rd_addr` is 0, and the first transaction is decoded as an opcode.
- R2: With opcode 0x0B, sent MSB first on `din[0]`, the 24 address bits follow MSB first on `din[0]` and then 8 dummy clocks. From the 41st falling edge on, data bits appear MSB first on `dout[1]`. Lanes 0, 2 and 3 stay 0.
- R3: With opcode 0xEB, sent MSB first on `din[0]`, the block then takes 6 address nibbles, 2 mode nibbles and 4 dummy nibbles on `din[3:0]`, most significant nibble first. `dout` is 0 through the mode and dummy nibbles. Each data byte then appears on `dout[3:0]` as two nibbles, high nibble first.
- R4: Data bytes stream with no gap, from consecutive array addresses starting at the captured address.
- R5: The read address wraps from 2^ADDR_W-1 to 0.
- R6: If the mode byte's upper nibble is 0xA, the next transaction starts directly with 6 address nibbles, followed by 2 mode nibbles and 4 dummy nibbles. Data follows from the 13th falling edge.
- R7: If the mode byte's upper nibble is not 0xA, the next transaction again expects a single-bit opcode.
- R8: A byte loaded while `wip` is 1 is output as zero.
- R9: Any opcode other than 0x0B or 0xEB, including 0x03, makes `dout` stay 0 until chip select rises. The next transaction is decoded normally.
- R10: Raising chip select mid-command discards the partial command and clears `dout` to 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; SCK and chip select are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock; bits are taken and data shifts on its falling edge |
| din | input | 4 | Input lines; single-bit phases use bit 0 only |
| dout | output | 4 | Output lines; single-bit data on bit 1, quad data on all four |
| rd_addr | output | ADDR_W | Array read address |
| rd_data | input | 8 | Array byte at `rd_addr`, same cycle |
| wip | input | 1 | Write in progress; forces loaded bytes to zero |

## Verification
A falling SCK edge is seen at the first rising `clk` edge where `sck` is low and its registered copy is still high. Every state, shift and byte-load effect of that edge is in place right after that `clk` edge. The bench therefore lowers SCK at a falling `clk` edge, lets one rising edge pass, and samples `dout` at the following falling `clk` edge before it raises SCK again. Checks are made per SCK fall. In single-bit mode the byte loaded on fall N shows its MSB on fall N+1. In quad mode it shows its high nibble on fall N+1 and its low nibble on fall N+2. The first data fall is fixed at 41 for fast read, 21 for quad read with opcode and 13 for a continuous quad read.

// File: rtl/qrd_pkg.sv
package qrd_pkg;

   // Transaction phase of the read responder.
   typedef enum logic [2:0] {
      ST_OPCODE,
      ST_FAST_ADDR,
      ST_FAST_DUMMY,
      ST_QUAD_ADDR,
      ST_MODE,
      ST_QUAD_DUMMY,
      ST_STREAM,
      ST_REJECT
   } qrd_state_e;

   localparam logic [7:0] OP_FAST_SINGLE = 8'h0B;
   localparam logic [7:0] OP_QUAD_IO     = 8'hEB;

   localparam int unsigned OPCODE_BITS = 8;
   localparam int unsigned ADDR_BITS   = 24;
   localparam int unsigned MODE_BITS   = 8;
   localparam int unsigned BYTE_BITS   = 8;
   localparam int unsigned LANES       = 4;

endpackage

// File: rtl/qrd_sck_edge.sv
module qrd_sck_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sck,
   output logic fall
);
   logic sck_q;

   // Held high while deselected so the first low SCK after select counts as a fall.
   always_ff @(posedge clk) begin
      if (!rst_n)    sck_q <= 1'b1;
      else if (cs_n) sck_q <= 1'b1;
      else           sck_q <= sck;
   end

   assign fall = !cs_n && sck_q && !sck;
endmodule

// File: rtl/qrd_shifter.sv
module qrd_shifter
   import qrd_pkg::*;
#(
   parameter int unsigned IN_W        = ADDR_BITS,
   parameter int unsigned SINGLE_LANE = 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clear,
   input  logic                   shift,
   input  logic                   quad,
   input  logic [LANES-1:0]       din,
   input  logic                   load,
   input  logic [BYTE_BITS-1:0]   load_byte,
   output logic [IN_W-1:0]        in_next,
   output logic [LANES-1:0]       dout
);
   localparam int unsigned OUT_W = BYTE_BITS + LANES;

   if (IN_W < BYTE_BITS + LANES) begin : g_bad_in_w
      $error("qrd_shifter: IN_W too small");
   end
   if (SINGLE_LANE >= LANES) begin : g_bad_lane
      $error("qrd_shifter: SINGLE_LANE out of range");
   end

   // Top input bit is never read again after a shift, so it is not stored.
   logic [IN_W-2:0]  in_q;
   logic [OUT_W-1:0] out_q;
   logic [OUT_W-1:0] out_shift;

   assign in_next   = quad ? {in_q[IN_W-LANES-1:0], din} : {in_q, din[0]};
   assign out_shift = quad ? {out_q[OUT_W-LANES-1:0], {LANES{1'b0}}}
                           : {out_q[OUT_W-2:0], 1'b0};

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         in_q  <= '0;
         out_q <= '0;
      end else if (shift) begin
         in_q  <= in_next[IN_W-2:0];
         out_q <= load ? {out_shift[OUT_W-1:BYTE_BITS], load_byte} : out_shift;
      end
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      if (i == SINGLE_LANE) begin : g_single
         assign dout[i] = quad ? out_q[BYTE_BITS+i] : out_q[BYTE_BITS];
      end else begin : g_quad_only
         assign dout[i] = quad ? out_q[BYTE_BITS+i] : 1'b0;
      end
   end
endmodule

// File: rtl/qrd_seq.sv
module qrd_seq
   import qrd_pkg::*;
#(
   parameter int unsigned FAST_DUMMY_BITS = 8,
   parameter int unsigned QUAD_DUMMY_BITS = 16,
   parameter logic [3:0]  CONT_NIBBLE     = 4'hA
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cs_n,
   input  logic                 fall,
   input  logic [BYTE_BITS-1:0] in_low,
   output logic                 quad,
   output qrd_state_e           state,
   output logic                 capture,
   output logic                 load
);
   localparam int unsigned MAX_AF = (ADDR_BITS > FAST_DUMMY_BITS) ? ADDR_BITS : FAST_DUMMY_BITS;
   localparam int unsigned MAXT   = (MAX_AF > QUAD_DUMMY_BITS) ? MAX_AF : QUAD_DUMMY_BITS;
   localparam int unsigned PH_W   = $clog2(MAXT + 1);

   if (FAST_DUMMY_BITS < 1) begin : g_bad_fast
      $error("qrd_seq: FAST_DUMMY_BITS must be at least 1");
   end
   if (QUAD_DUMMY_BITS < LANES || (QUAD_DUMMY_BITS % LANES) != 0) begin : g_bad_quad
      $error("qrd_seq: QUAD_DUMMY_BITS must be a nonzero multiple of the lane count");
   end

   qrd_state_e      st_q, st_next;
   logic            quad_q;
   logic [3:0]      mode_hi_q;
   logic [PH_W-1:0] phase_q, phase_next, target, step;
   logic            hit;

   assign step       = quad_q ? PH_W'(LANES) : PH_W'(1);
   assign phase_next = phase_q + step;

   always_comb begin
      case (st_q)
         ST_OPCODE:     target = PH_W'(OPCODE_BITS);
         ST_FAST_ADDR:  target = PH_W'(ADDR_BITS);
         ST_FAST_DUMMY: target = PH_W'(FAST_DUMMY_BITS);
         ST_QUAD_ADDR:  target = PH_W'(ADDR_BITS);
         ST_MODE:       target = PH_W'(MODE_BITS);
         ST_QUAD_DUMMY: target = PH_W'(QUAD_DUMMY_BITS);
         ST_STREAM:     target = PH_W'(BYTE_BITS);
         default:       target = '0;
      endcase
   end

   assign hit = fall && (st_q != ST_REJECT) && (phase_next == target);

   always_comb begin
      case (st_q)
         ST_OPCODE: begin
            if (in_low == OP_FAST_SINGLE)  st_next = ST_FAST_ADDR;
            else if (in_low == OP_QUAD_IO) st_next = ST_QUAD_ADDR;
            else                           st_next = ST_REJECT;
         end
         ST_FAST_ADDR:  st_next = ST_FAST_DUMMY;
         ST_FAST_DUMMY: st_next = ST_STREAM;
         ST_QUAD_ADDR:  st_next = ST_MODE;
         ST_MODE:       st_next = ST_QUAD_DUMMY;
         ST_QUAD_DUMMY: st_next = ST_STREAM;
         ST_STREAM:     st_next = ST_STREAM;
         default:       st_next = ST_REJECT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_OPCODE;
         quad_q    <= 1'b0;
         mode_hi_q <= 4'h0;
         phase_q   <= '0;
      end else if (cs_n) begin
         phase_q <= '0;
         if (quad_q && mode_hi_q == CONT_NIBBLE) begin
            st_q <= ST_QUAD_ADDR;
         end else begin
            st_q   <= ST_OPCODE;
            quad_q <= 1'b0;
         end
      end else if (fall && st_q != ST_REJECT) begin
         phase_q <= hit ? '0 : phase_next;
         if (hit) begin
            st_q <= st_next;
            if (st_q == ST_OPCODE && in_low == OP_QUAD_IO) begin
               quad_q    <= 1'b1;
               mode_hi_q <= 4'h0;
            end
            if (st_q == ST_MODE) mode_hi_q <= in_low[BYTE_BITS-1:BYTE_BITS-4];
         end
      end
   end

   assign capture = hit && (st_q == ST_FAST_ADDR || st_q == ST_QUAD_ADDR);
   assign load    = hit && (st_q == ST_FAST_DUMMY || st_q == ST_QUAD_DUMMY || st_q == ST_STREAM);
   assign quad    = quad_q;
   assign state   = st_q;

   // R3: every quad-path phase runs with the four-lane width
   a_r3_quad_path: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_QUAD_ADDR || st_q == ST_MODE || st_q == ST_QUAD_DUMMY) |-> quad_q);

   // R2: the fast-read address and dummy phases stay single-bit
   a_r2_single_path: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_FAST_ADDR || st_q == ST_FAST_DUMMY) |-> !quad_q);
endmodule

// File: rtl/qrd_addr.sv
module qrd_addr #(
   parameter int unsigned ADDR_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [ADDR_W-1:0] cap_value,
   input  logic              step,
   output logic [ADDR_W-1:0] addr
);
   logic [ADDR_W-1:0] addr_q;

   // Natural wrap of the ADDR_W-bit counter gives modulo-array addressing.
   always_ff @(posedge clk) begin
      if (!rst_n)       addr_q <= '0;
      else if (capture) addr_q <= cap_value;
      else if (step)    addr_q <= addr_q + 1'b1;
   end

   assign addr = addr_q;
endmodule

// File: rtl/qrd_read_responder.sv
module qrd_read_responder
   import qrd_pkg::*;
#(
   parameter int unsigned ADDR_W          = 24,
   parameter int unsigned FAST_DUMMY_BITS = 8,
   parameter int unsigned QUAD_DUMMY_BITS = 16,
   parameter int unsigned SINGLE_LANE     = 1,
   parameter logic [3:0]  CONT_NIBBLE     = 4'hA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sck,
   input  logic [3:0]        din,
   output logic [3:0]        dout,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [7:0]        rd_data,
   input  logic              wip
);
   if (ADDR_W < 8 || ADDR_W > ADDR_BITS) begin : g_bad_addr_w
      $error("qrd_read_responder: ADDR_W must be 8..24");
   end

   logic                 fall, quad, capture, load;
   qrd_state_e           state;
   logic [ADDR_BITS-1:0] in_next;
   logic [BYTE_BITS-1:0] load_byte;

   assign load_byte = wip ? '0 : rd_data;

   qrd_sck_edge u_edge (
      .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .sck (sck), .fall (fall)
   );

   qrd_shifter #(.IN_W(ADDR_BITS), .SINGLE_LANE(SINGLE_LANE)) u_shift (
      .clk (clk), .rst_n (rst_n), .clear (cs_n), .shift (fall), .quad (quad),
      .din (din), .load (load), .load_byte (load_byte),
      .in_next (in_next), .dout (dout)
   );

   qrd_seq #(
      .FAST_DUMMY_BITS (FAST_DUMMY_BITS),
      .QUAD_DUMMY_BITS (QUAD_DUMMY_BITS),
      .CONT_NIBBLE     (CONT_NIBBLE)
   ) u_seq (
      .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .fall (fall),
      .in_low (in_next[BYTE_BITS-1:0]), .quad (quad), .state (state),
      .capture (capture), .load (load)
   );

   qrd_addr #(.ADDR_W(ADDR_W)) u_addr (
      .clk (clk), .rst_n (rst_n), .capture (capture),
      .cap_value (in_next[ADDR_W-1:0]), .step (load), .addr (rd_addr)
   );

   // R10: deselect empties the output path by the next cycle
   a_r10_deselect_clear: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> dout == 4'h0);

   // R9: a rejected opcode keeps the output lines quiet
   a_r9_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_REJECT) |-> dout == 4'h0);

   // R4 and R5: each byte load advances the array address by one, wrapping
   a_r4_addr_advance: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> rd_addr == ADDR_W'($past(rd_addr) + 1'b1));

   // R8: a byte loaded during a write in progress enters the shifter as zero
   a_r8_wip_blank: assert property (@(posedge clk) disable iff (!rst_n)
      (load && wip) |=> u_shift.out_q[7:0] == 8'h00);
endmodule

// File: tb/qrd_read_responder_tb.sv
module qrd_read_responder_tb;
   localparam int ADDR_W = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1;
   logic sck = 1'b1;
   logic wip = 1'b0;
   logic [3:0] din = 4'h0;
   logic [3:0] dout;
   logic [ADDR_W-1:0] rd_addr;
   logic [7:0] rd_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   function automatic logic [7:0] pat(input logic [23:0] a);
      return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
   endfunction

   assign rd_data = pat(rd_addr);

   qrd_read_responder u_dut (
      .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .sck (sck), .din (din),
      .dout (dout), .rd_addr (rd_addr), .rd_data (rd_data), .wip (wip)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // One SCK fall; q is dout as seen after the fall has been processed.
   task automatic fall(input logic [3:0] d, output logic [3:0] q);
      sck = 1'b0; din = d;
      @(posedge clk); @(negedge clk);
      q = dout;
      sck = 1'b1;
      @(posedge clk); @(negedge clk);
   endtask

   task automatic select();
      cs_n = 1'b0;
      @(negedge clk);
   endtask

   task automatic deselect();
      cs_n = 1'b1; sck = 1'b1; din = 4'h0;
      repeat (3) @(negedge clk);
   endtask

   task automatic send_single(input logic [7:0] b);
      logic [3:0] q;
      for (int i = 7; i >= 0; i--) fall({3'b000, b[i]}, q);
   endtask

   task automatic read_single(input logic [7:0] exp, input string req);
      logic [3:0] q;
      logic [7:0] got;
      logic [2:0] side;
      side = 3'b000;
      for (int i = 7; i >= 0; i--) begin
         fall(4'h0, q);
         got[i] = q[1];
         side = side | {q[3:2], q[0]};
      end
      check(req, {24'h0, got}, {24'h0, exp});
      check("R2 unused lanes", {29'h0, side}, 32'h0);
   endtask

   task automatic read_quad(input logic [7:0] exp, input string req);
      logic [3:0] hi, lo;
      fall(4'h0, hi);
      fall(4'h0, lo);
      check(req, {24'h0, hi, lo}, {24'h0, exp});
   endtask

   task automatic fast_read(input logic [23:0] a, input int n, input string req);
      logic [3:0] q;
      select();
      send_single(8'h0B);
      for (int i = 23; i >= 0; i--) fall({3'b000, a[i]}, q);
      for (int i = 0; i < 8; i++) fall(4'h0, q);
      for (int k = 0; k < n; k++) begin
         logic [23:0] ak;
         ak = a + 24'(k);
         read_single(wip ? 8'h00 : pat(ak), req);
      end
      deselect();
   endtask

   task automatic quad_read(input logic [23:0] a, input logic [7:0] mode, input int n,
                            input bit cont, input string req);
      logic [3:0] q;
      logic [3:0] acc;
      select();
      if (!cont) send_single(8'hEB);
      for (int i = 5; i >= 0; i--) fall(a[i*4 +: 4], q);
      acc = 4'h0;
      fall(mode[7:4], q); acc = acc | q;
      fall(mode[3:0], q); acc = acc | q;
      for (int i = 0; i < 4; i++) begin
         fall(4'h0, q);
         acc = acc | q;
      end
      check({req, " quiet before data"}, {28'h0, acc}, 32'h0);
      for (int k = 0; k < n; k++) begin
         logic [23:0] ak;
         ak = a + 24'(k);
         read_quad(pat(ak), req);
      end
      deselect();
   endtask

   task automatic t_reset();
      check("R1 dout after reset", {28'h0, dout}, 32'h0);
      check("R1 rd_addr after reset", {8'h0, rd_addr}, 32'h0);
   endtask

   task automatic t_fast();
      fast_read(24'h012345, 3, "R2 R4 fast read");
   endtask

   task automatic t_quad_cont();
      quad_read(24'h00ABCD, 8'hA5, 4, 1'b0, "R3 R4 quad read");
      quad_read(24'h100200, 8'hAF, 2, 1'b1, "R6 continuous read");
      quad_read(24'h3456F0, 8'h5F, 2, 1'b1, "R6 continuous read, leaving");
   endtask

   task automatic t_exit();
      fast_read(24'h000010, 2, "R7 opcode after leaving");
      quad_read(24'h0000F0, 8'h00, 2, 1'b0, "R7 quad opcode after leaving");
      fast_read(24'h000033, 1, "R7 no continuous after mode 00");
   endtask

   task automatic t_wrap();
      quad_read(24'hFFFFFE, 8'h00, 4, 1'b0, "R5 wrap quad");
      fast_read(24'hFFFFFF, 2, "R5 wrap single");
   endtask

   task automatic t_wip();
      wip = 1'b1;
      fast_read(24'h000400, 2, "R8 write in progress");
      wip = 1'b0;
      fast_read(24'h000400, 1, "R8 after write done");
   endtask

   task automatic t_reject();
      logic [3:0] q, acc;
      select();
      send_single(8'h03);
      acc = 4'h0;
      for (int i = 0; i < 40; i++) begin
         fall(4'hF, q);
         acc = acc | q;
      end
      check("R9 slow read rejected", {28'h0, acc}, 32'h0);
      deselect();
      select();
      send_single(8'h9F);
      acc = 4'h0;
      for (int i = 0; i < 16; i++) begin
         fall(4'hF, q);
         acc = acc | q;
      end
      check("R9 other opcode rejected", {28'h0, acc}, 32'h0);
      deselect();
      fast_read(24'h000020, 1, "R9 recovery");
   endtask

   task automatic t_abort();
      logic [3:0] q;
      select();
      send_single(8'h0B);
      for (int i = 0; i < 12; i++) fall(4'h1, q);
      cs_n = 1'b1; sck = 1'b1;
      @(posedge clk); @(negedge clk);
      check("R10 dout cleared on deselect", {28'h0, dout}, 32'h0);
      deselect();
      fast_read(24'h000777, 2, "R10 after abort");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fast();
      t_quad_cont();
      t_exit();
      t_wrap();
      t_wip();
      t_reject();
      t_abort();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule